// File: doc/BRIEF.md
# MLSE Euclidean Branch Metric Unit

This unit supplies incremental branch metrics to the add-compare-select stage of a maximum-likelihood sequence estimation equalizer. Software or a controller loads up to six complex channel taps, one received complex sample and a constraint length, then pulses `start`. For every hypothesis index `k` from 0 to 2^C − 1 the unit convolves the hypothesised binary symbols with the taps, which gives an estimated received sample. It then forms the absolute I and Q errors against the real sample, saturates each at 255, squares and adds them, and emits the upper 16 bits of the 17-bit sum.

Metrics come out one per clock with a valid flag and the hypothesis index. A single-cycle `done` pulse closes the stream. The operands are captured when the start is accepted, so the ports may be reloaded for the next sample while a stream is running. A start that arrives while the unit is busy is dropped.

Top module: `mlse_bm_top`

## Requirements
- R1: After an accepted start, exactly 2^C metrics are emitted on consecutive cycles with `met_idx` running 0, 1, …, 2^C − 1, where C is the effective constraint length.
- R2: Tap Hj occupies `taps[16j+15:16j]`, with its in-phase part (8-bit two's complement) in bits `[16j+15:16j+8]` and its quadrature part in `[16j+7:16j]`. For index k, bit j of k selects +Hj when 0 and −Hj when 1, and the estimate is the sum over the active taps.
- R3: Taps Hj with j ≥ C contribute nothing to the estimate.
- R4: The I error is |rx_i − estI| and the Q error is |rx_q − estQ|, with `rx_i` and `rx_q` taken as 10-bit two's complement. Each error saturates at 255.
- R5: `metric` = (errI² + errQ²) >> 1, which is bits 16..1 of the 17-bit sum, so it never exceeds 65025.
- R6: If `start` is sampled high while idle, `busy` is high after that edge, and the metric for k = 0 is valid after the next edge.
- R7: `done` is high for exactly one cycle, namely the cycle right after the last valid metric, and never together with `met_valid`.
- R8: `busy` is high from an accepted start until `done`. A `start` while `busy` is high is ignored, and the stream carries on unchanged.
- R9: `clen`, `taps`, `rx_i` and `rx_q` are captured at the accepted start. Changes to them during a stream have no effect on that stream.
- R10: Synchronous active-high `rst` clears `met_valid`, `done` and `busy` and aborts a running stream.
- R11: A `clen` value below 2 is treated as 2, and a value above 6 is treated as 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a metric stream (ignored while busy) |
| clen | input | 3 | Constraint length C |
| taps | input | 96 | Six packed complex taps, H0 in the low 16 bits |
| rx_i | input | 10 | Received in-phase sample, two's complement |
| rx_q | input | 10 | Received quadrature sample, two's complement |
| busy | output | 1 | A stream is in progress |
| met_valid | output | 1 | `metric` and `met_idx` are valid |
| met_idx | output | 6 | Hypothesis index k of the current metric |
| metric | output | 16 | Branch metric |
| done | output | 1 | One-cycle pulse after the final metric |

## Verification
Two things can fall in the same cycle: metric emission and a fresh start, or metric emission and a change of operands at the ports. The bench raises `start` in the middle of a stream and judges the result by an unbroken index sequence and an exact metric count. On another vector it overwrites every operand, including `clen`, the cycle after the start is accepted. It then requires every metric and the count to match the values computed from the operands captured at the start.

// File: rtl/mlse_bm_pkg.sv
package mlse_bm_pkg;

    localparam int TAP_W    = 8;
    localparam int SAMP_W   = 10;
    localparam int MAX_TAPS = 6;
    localparam int MIN_CL   = 2;
    localparam int CL_W     = 3;
    // one guard bit above the sample width keeps any tap sum exact
    localparam int EST_W    = SAMP_W + 1;
    localparam int DIFF_W   = EST_W + 1;
    localparam int ERR_W    = 8;
    localparam int SUM_W    = 2 * ERR_W + 1;
    localparam int MET_W    = SUM_W - 1;
    localparam int IDX_W    = MAX_TAPS;
    localparam int TAPREG_W = 2 * TAP_W;
    localparam int TAPS_W   = MAX_TAPS * TAPREG_W;
    localparam int ERR_MAX  = (1 << ERR_W) - 1;

    typedef struct packed {
        logic signed [TAP_W-1:0] re;
        logic signed [TAP_W-1:0] im;
    } tap_t;

    typedef struct packed {
        logic signed [SAMP_W-1:0] re;
        logic signed [SAMP_W-1:0] im;
    } samp_t;

    typedef struct packed {
        logic signed [EST_W-1:0] re;
        logic signed [EST_W-1:0] im;
    } est_t;

    typedef struct packed {
        logic [ERR_W-1:0] re;
        logic [ERR_W-1:0] im;
    } err_t;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_RUN
    } seq_state_e;

    function automatic logic [CL_W-1:0] clamp_clen(input logic [CL_W-1:0] c);
        if (c < CL_W'(MIN_CL))   return CL_W'(MIN_CL);
        if (c > CL_W'(MAX_TAPS)) return CL_W'(MAX_TAPS);
        return c;
    endfunction

    function automatic logic signed [EST_W-1:0] widen_tap(input logic [TAP_W-1:0] t);
        return $signed({{(EST_W-TAP_W){t[TAP_W-1]}}, t});
    endfunction

    function automatic logic signed [DIFF_W-1:0] sub_ext(input logic [SAMP_W-1:0] r,
                                                         input logic [EST_W-1:0] e);
        return $signed({{(DIFF_W-SAMP_W){r[SAMP_W-1]}}, r})
             - $signed({{(DIFF_W-EST_W){e[EST_W-1]}}, e});
    endfunction

    function automatic logic [ERR_W-1:0] sat_abs(input logic signed [DIFF_W-1:0] d);
        logic [DIFF_W-1:0] mag;
        mag = d[DIFF_W-1] ? DIFF_W'(-d) : DIFF_W'(d);
        return (mag > DIFF_W'(ERR_MAX)) ? ERR_W'(ERR_MAX) : mag[ERR_W-1:0];
    endfunction

endpackage

// File: rtl/bm_sequencer.sv
module bm_sequencer
    import mlse_bm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [CL_W-1:0]  clen_q,
    output logic             active,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    seq_state_e       state;
    logic [IDX_W-1:0] limit;

    assign limit  = IDX_W'((32'd1 << clen_q) - 32'd1);
    assign active = (state == SEQ_RUN);
    assign last   = active && (idx == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (accept) begin
                        state <= SEQ_RUN;
                        idx   <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (idx == limit) begin
                        state <= SEQ_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bm_estimator.sv
module bm_estimator
    import mlse_bm_pkg::*;
(
    input  logic [TAPS_W-1:0] taps_q,
    input  logic [CL_W-1:0]   clen_q,
    input  logic [IDX_W-1:0]  hyp,
    output est_t              est
);
    est_t term [MAX_TAPS];

    for (genvar j = 0; j < MAX_TAPS; j++) begin : g_tap
        tap_t t;
        est_t pos;
        est_t neg;
        assign t      = tap_t'(taps_q[j*TAPREG_W +: TAPREG_W]);
        assign pos.re = widen_tap(t.re);
        assign pos.im = widen_tap(t.im);
        assign neg.re = -pos.re;
        assign neg.im = -pos.im;
        assign term[j] = (CL_W'(j) < clen_q) ? (hyp[j] ? neg : pos) : '0;
    end

    always_comb begin
        est = '0;
        for (int j = 0; j < MAX_TAPS; j++) begin
            est.re = est.re + term[j].re;
            est.im = est.im + term[j].im;
        end
    end
endmodule

// File: rtl/bm_metric.sv
module bm_metric
    import mlse_bm_pkg::*;
(
    input  samp_t             rx,
    input  est_t              est,
    output logic [MET_W-1:0]  metric
);
    err_t                err;
    logic [2*ERR_W-1:0]  sq_re;
    logic [2*ERR_W-1:0]  sq_im;
    logic [SUM_W-1:0]    sum;

    assign err.re = sat_abs(sub_ext(rx.re, est.re));
    assign err.im = sat_abs(sub_ext(rx.im, est.im));
    assign sq_re  = {{ERR_W{1'b0}}, err.re} * {{ERR_W{1'b0}}, err.re};
    assign sq_im  = {{ERR_W{1'b0}}, err.im} * {{ERR_W{1'b0}}, err.im};
    assign sum    = {1'b0, sq_re} + {1'b0, sq_im};
    assign metric = sum[SUM_W-1:1];
endmodule

// File: rtl/mlse_bm_top.sv
module mlse_bm_top
    import mlse_bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CL_W-1:0]   clen,
    input  logic [TAPS_W-1:0] taps,
    input  logic [SAMP_W-1:0] rx_i,
    input  logic [SAMP_W-1:0] rx_q,
    output logic              busy,
    output logic              met_valid,
    output logic [IDX_W-1:0]  met_idx,
    output logic [MET_W-1:0]  metric,
    output logic              done
);
    logic [TAPS_W-1:0] taps_q;
    logic [CL_W-1:0]   clen_q;
    samp_t             rx_q_s;
    logic              accept;
    logic              active;
    logic              last;
    logic              last_q;
    logic [IDX_W-1:0]  idx;
    est_t              est;
    logic [MET_W-1:0]  met_c;

    assign busy   = active || met_valid;
    assign accept = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            taps_q <= '0;
            clen_q <= CL_W'(MIN_CL);
            rx_q_s <= '0;
        end else if (accept) begin
            taps_q    <= taps;
            clen_q    <= clamp_clen(clen);
            rx_q_s.re <= rx_i;
            rx_q_s.im <= rx_q;
        end
    end

    bm_sequencer i_seq (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .clen_q (clen_q),
        .active (active),
        .idx    (idx),
        .last   (last)
    );

    bm_estimator i_est (
        .taps_q (taps_q),
        .clen_q (clen_q),
        .hyp    (idx),
        .est    (est)
    );

    bm_metric i_met (
        .rx     (rx_q_s),
        .est    (est),
        .metric (met_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            met_valid <= 1'b0;
            met_idx   <= '0;
            metric    <= '0;
            last_q    <= 1'b0;
            done      <= 1'b0;
        end else begin
            met_valid <= active;
            last_q    <= last;
            done      <= met_valid && last_q;
            if (active) begin
                met_idx <= idx;
                metric  <= met_c;
            end
        end
    end
endmodule

// File: rtl/mlse_bm_chk.sv
module mlse_bm_chk
    import mlse_bm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             met_valid,
    input logic [IDX_W-1:0] met_idx,
    input logic [MET_W-1:0] metric,
    input logic             done
);
    // R1
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        met_valid && $past(met_valid) |-> met_idx == IDX_W'($past(met_idx) + 1'b1));

    // R1
    idx_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(met_valid) |-> met_idx == '0);

    // R5
    metric_bound_chk: assert property (@(posedge clk) disable iff (rst)
        met_valid |-> metric <= MET_W'(65025));

    // R7
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !met_valid && $past(met_valid));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    busy_cover_chk: assert property (@(posedge clk) disable iff (rst)
        met_valid |-> busy);
endmodule

bind mlse_bm_top mlse_bm_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .met_valid (met_valid),
    .met_idx   (met_idx),
    .metric    (metric),
    .done      (done)
);

// File: tb/test_mlse_bm_top.sv
module test_mlse_bm_top;

    typedef struct packed {
        logic [2:0]  clen;
        logic [95:0] taps;
        logic [9:0]  ri;
        logic [9:0]  rq;
        logic [6:0]  n;
        logic        scr;
        logic        restart;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VEC [NVEC] = '{
        '{clen: 3'd2, taps: 96'h6464_7F7F_8080_1111_0307_0AFB, ri: 10'h014, rq: 10'h3FD, n: 7'd4,  scr: 1'b0, restart: 1'b0},
        '{clen: 3'd3, taps: 96'h0000_0000_0000_F010_1CE4_2008, ri: 10'h050, rq: 10'h3C0, n: 7'd8,  scr: 1'b0, restart: 1'b0},
        '{clen: 3'd6, taps: 96'h0505_F6F6_0C0C_E818_10F0_3020, ri: 10'h010, rq: 10'h3F0, n: 7'd64, scr: 1'b1, restart: 1'b0},
        '{clen: 3'd4, taps: 96'h0000_0000_8080_8080_8080_8080, ri: 10'h1FF, rq: 10'h200, n: 7'd16, scr: 1'b0, restart: 1'b1},
        '{clen: 3'd7, taps: 96'h0102_0304_0506_0708_090A_0B0C, ri: 10'h005, rq: 10'h3FB, n: 7'd64, scr: 1'b0, restart: 1'b0},
        '{clen: 3'd1, taps: 96'h7F80_0000_0000_0000_4040_C0C0, ri: 10'h100, rq: 10'h0FF, n: 7'd4,  scr: 1'b0, restart: 1'b0},
        '{clen: 3'd5, taps: 96'h0000_2222_DDDD_1234_F00F_7F01, ri: 10'h200, rq: 10'h1FF, n: 7'd32, scr: 1'b0, restart: 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  clen = '0;
    logic [95:0] taps = '0;
    logic [9:0]  rx_i = '0;
    logic [9:0]  rx_q = '0;
    logic        busy;
    logic        met_valid;
    logic [5:0]  met_idx;
    logic [15:0] metric;
    logic        done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    mlse_bm_top i_mlse_bm_top (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .clen      (clen),
        .taps      (taps),
        .rx_i      (rx_i),
        .rx_q      (rx_q),
        .busy      (busy),
        .met_valid (met_valid),
        .met_idx   (met_idx),
        .metric    (metric),
        .done      (done)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not end, act=%0d cycles exp<20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_clen(input int c);
        if (c < 2) return 2;
        if (c > 6) return 6;
        return c;
    endfunction

    function automatic int model(input int c, input logic [95:0] t,
                                 input logic [9:0] ri, input logic [9:0] rq, input int k);
        int ei = 0;
        int eq = 0;
        int ai;
        int aq;
        for (int j = 0; j < 6; j++) begin
            if (j < c) begin
                int hi = $signed(t[16*j+8 +: 8]);
                int hq = $signed(t[16*j +: 8]);
                if (k[j]) begin
                    ei -= hi;
                    eq -= hq;
                end else begin
                    ei += hi;
                    eq += hq;
                end
            end
        end
        ai = $signed(ri) - ei;
        aq = $signed(rq) - eq;
        if (ai < 0) ai = -ai;
        if (aq < 0) aq = -aq;
        if (ai > 255) ai = 255;
        if (aq > 255) aq = 255;
        return (ai * ai + aq * aq) / 2;
    endfunction

    task automatic run_vec(input vec_t v);
        int  n = 0;
        bit  seen_done = 0;
        int  c = eff_clen(int'(v.clen));
        @(negedge clk);
        clen  = v.clen;
        taps  = v.taps;
        rx_i  = v.ri;
        rx_q  = v.rq;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (v.scr) begin
            // R9: reload every operand right after the start is taken
            taps = ~v.taps;
            rx_i = ~v.ri;
            rx_q = ~v.rq;
            clen = 3'd2;
        end
        for (int i = 0; i < 100 && !seen_done; i++) begin
            @(posedge clk);
            #1;
            start = 1'b0;
            if (met_valid) begin
                chk(met_idx == 6'(n), "R1 index order", int'(met_idx), n);
                chk(int'(metric) == model(c, v.taps, v.ri, v.rq, n),
                    "R2 R3 R4 R5 R9 R11 metric value", int'(metric),
                    model(c, v.taps, v.ri, v.rq, n));
                n++;
                // R8: a start in mid stream must be dropped
                if (v.restart && n == 3) start = 1'b1;
            end
            if (done) begin
                seen_done = 1;
                chk(!met_valid, "R7 done apart from valid", int'(met_valid), 0);
                chk(n == int'(v.n), "R1 R11 metric count", n, int'(v.n));
                chk(!busy, "R8 busy ends with done", int'(busy), 0);
            end
        end
        chk(seen_done, "R7 done seen", int'(seen_done), 1);
        @(posedge clk);
        #1;
        chk(!done, "R7 done lasts one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: state under reset
        chk(!met_valid && !done && !busy, "R10 reset outputs",
            int'({met_valid, done, busy}), 0);
        @(negedge clk);
        rst = 1'b0;

        // R6: latency from start to first metric
        @(negedge clk);
        clen  = VEC[0].clen;
        taps  = VEC[0].taps;
        rx_i  = VEC[0].ri;
        rx_q  = VEC[0].rq;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #0;
        chk(busy && !met_valid, "R6 busy after start edge",
            int'({busy, met_valid}), 2);
        @(posedge clk);
        #1;
        chk(met_valid && met_idx == 6'd0, "R6 first metric valid",
            int'({met_valid, met_idx}), 64);
        chk(int'(metric) == model(2, VEC[0].taps, VEC[0].ri, VEC[0].rq, 0),
            "R6 first metric value", int'(metric),
            model(2, VEC[0].taps, VEC[0].ri, VEC[0].rq, 0));
        @(negedge clk);
        // R10: reset in mid stream
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk(!met_valid && !done && !busy, "R10 reset aborts stream",
            int'({met_valid, done, busy}), 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) begin
            @(posedge clk);
            #1;
            chk(!met_valid && !busy, "R10 stays idle after reset",
                int'({met_valid, busy}), 0);
        end

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            run_vec(VEC[v]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule